// File: doc/BRIEF.md
# Four-Stage Pseudo-Random Sequence Generator with Zero-State Recovery

This block produces a repeatable pseudo-random bit stream from a small shift register whose feedback is the XOR of selected stages. A tap-mask parameter chooses the characteristic polynomial, and a second parameter picks one of two feedback layouts. In the external-XOR layout, feedback is computed at the head of the register. In the internal-XOR layout, the bit leaving the tail is folded into the tapped stages as they shift. For the same polynomial, both layouts give an output stream that obeys the same linear recurrence.

A plain XOR-feedback register that reaches the all-zero state stays there forever. This block detects that state and flips the feedback bit while it lasts, so the register leaves zero on the next enabled clock. In every non-zero state the detector is silent, which leaves the maximal-length sequence exactly as it would be without it. A seed can be loaded at any time. The parallel state and the serial bit (stage 0) are both registered outputs.

Top module: `prbs_gen`

## Requirements
- R1: A synchronous active-high `rst` sets the state to 0001 (stage 0 set, all others clear). Reset takes priority over load and enable.
- R2: When `load` is high and `rst` is low, the next state equals `seed`, whatever the value of `en`.
- R3: When `rst`, `load` and `en` are all low, the state does not change.
- R4: In the external-XOR layout, an enabled clock moves each stage i+1 into stage i. Stage W-1 receives the XOR of the stages whose tap-mask bit is set. `serial` always equals stage 0.
- R5: In the external-XOR layout, an enabled clock from state 0000 gives 1000.
- R6: With taps on stages 1 and 0 (x^4+x+1, mask 0011), the register visits all 15 non-zero states and returns to its seed after exactly 15 clocks.
- R7: In a 3-stage build with mask 011 (x^3+x+1), the period from seed 001 is 7.
- R8: With the non-primitive mask 0101 (x^4+x^2+1), the period from seed 1000 is 6.
- R9: In the internal-XOR layout, an enabled clock sets stage W-1 to (stage 0 XOR zero-detect). It also sets stage i to stage i+1 XOR (that same bit AND mask bit W-1-i). For mask 0011, the serial stream satisfies y[t+4] = y[t+1] XOR y[t] and has period 15. From state 0000, one enabled clock gives 1100.
- R10: With mask 1001 (x^4+x^3+1), the period from seed 1000 is 15.
- R11: With a mask whose bit 0 is set, an enabled clock from any non-zero state never gives the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to 0001 |
| en | input | 1 | Advance the sequence one step |
| load | input | 1 | Load `seed` into the register (beats `en`) |
| seed | input | WIDTH | Value to load |
| state | output | WIDTH | Registered parallel state |
| serial | output | 1 | Registered serial output, stage 0 |

## Verification
The bench goes after the zero state from both directions. It loads 0000 directly and checks that one clock escapes it: an escape that is missing would freeze the output at zero, and one wired to the wrong end would land on a state other than 1000 or 1100. It measures the period from a seed for the primitive, reversed and non-primitive polynomials and for a three-stage build. A mis-indexed tap, a shift in the wrong direction or a detector that fires outside zero would show up as a wrong count or as a missed state. The internal-XOR layout is checked against the recurrence of its polynomial, which catches a tap mask applied in reverse. Priority between reset, load and enable is checked by asserting them together.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  typedef enum logic {
    ARCH_EXT_XOR = 1'b0,
    ARCH_INT_XOR = 1'b1
  } arch_e;
endpackage

// File: rtl/prbs_zero_det.sv
module prbs_zero_det #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);
  assign all_zero = ~|vec;
endmodule

// File: rtl/prbs_step_ext.sv
// External-XOR step: feedback enters the top stage, everything moves toward stage 0.
module prbs_step_ext #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b0011
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             kick,
  output logic [WIDTH-1:0] nxt
);
  logic head_bit;
  assign head_bit = (^(cur & TAPS)) ^ kick;
  assign nxt      = {head_bit, cur[WIDTH-1:1]};
endmodule

// File: rtl/prbs_step_int.sv
// Internal-XOR step: the bit leaving stage 0 is folded into tapped stages.
module prbs_step_int #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b0011
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             kick,
  output logic [WIDTH-1:0] nxt
);
  logic tail_bit;
  assign tail_bit      = cur[0] ^ kick;
  assign nxt[WIDTH-1]  = tail_bit;
  for (genvar i = 0; i < WIDTH - 1; i++) begin : g_stage
    assign nxt[i] = cur[i+1] ^ (tail_bit & TAPS[WIDTH-1-i]);
  end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int                WIDTH     = 4,
  parameter logic [WIDTH-1:0]  TAPS      = 4'b0011,
  parameter prbs_pkg::arch_e   ARCH      = prbs_pkg::ARCH_EXT_XOR,
  parameter logic [WIDTH-1:0]  RESET_VAL = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state,
  output logic             serial
);
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] step_d;
  logic             zero_hit;

  prbs_zero_det #(.WIDTH(WIDTH)) u_zdet (
    .vec      (reg_q),
    .all_zero (zero_hit)
  );

  if (ARCH == prbs_pkg::ARCH_INT_XOR) begin : g_int
    prbs_step_int #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
      .cur  (reg_q),
      .kick (zero_hit),
      .nxt  (step_d)
    );
  end else begin : g_ext
    prbs_step_ext #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
      .cur  (reg_q),
      .kick (zero_hit),
      .nxt  (step_d)
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       reg_q <= RESET_VAL;
    else if (load) reg_q <= seed;
    else if (en)   reg_q <= step_d;
  end

  assign state  = reg_q;
  assign serial = reg_q[0];
endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk #(
  parameter int                WIDTH     = 4,
  parameter logic [WIDTH-1:0]  TAPS      = 4'b0011,
  parameter prbs_pkg::arch_e   ARCH      = prbs_pkg::ARCH_EXT_XOR,
  parameter logic [WIDTH-1:0]  RESET_VAL = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] state,
  input logic             serial
);
  // R1
  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state == RESET_VAL);

  // R2
  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));

  // R3
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state));

  // R11
  p_no_trap_r11: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state != '0 && TAPS[0]) |=> state != '0);

  // R5 / R9: zero is always left
  p_escape_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == '0) |=> state != '0);

  if (ARCH == prbs_pkg::ARCH_EXT_XOR) begin : g_ext
    // R4
    p_shift_down_r4: assert property (@(posedge clk) disable iff (rst)
      (en && !load) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));
  end else begin : g_int
    // R9
    p_tail_fold_r9: assert property (@(posedge clk) disable iff (rst)
      (en && !load) |=> state[WIDTH-1] == ($past(serial) ^ ($past(state) == '0)));
  end
endmodule

bind prbs_gen prbs_gen_chk #(
  .WIDTH(WIDTH), .TAPS(TAPS), .ARCH(ARCH), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .load(load),
  .seed(seed), .state(state), .serial(serial)
);

// File: tb/prbs_gen_test.sv
module prbs_gen_test;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [3:0] seed = 4'b0000;
  logic [2:0] seed3 = 3'b001;

  logic [3:0] st_a, st_b, st_c, st_g;
  logic [2:0] st_w;
  logic       ser_a, ser_b, ser_c, ser_g, ser_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  prbs_gen #(.WIDTH(4), .TAPS(4'b0011), .ARCH(prbs_pkg::ARCH_EXT_XOR)) uut (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(st_a), .serial(ser_a));
  prbs_gen #(.WIDTH(4), .TAPS(4'b1001), .ARCH(prbs_pkg::ARCH_EXT_XOR)) u_rev (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(st_b), .serial(ser_b));
  prbs_gen #(.WIDTH(4), .TAPS(4'b0101), .ARCH(prbs_pkg::ARCH_EXT_XOR)) u_np (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(st_c), .serial(ser_c));
  prbs_gen #(.WIDTH(4), .TAPS(4'b0011), .ARCH(prbs_pkg::ARCH_INT_XOR)) u_gal (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(st_g), .serial(ser_g));
  prbs_gen #(.WIDTH(3), .TAPS(3'b011), .ARCH(prbs_pkg::ARCH_EXT_XOR)) u_w3 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed3), .state(st_w), .serial(ser_w));

  typedef struct {
    logic [3:0] st;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(bit ok, string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference step from R4/R5 (external XOR, top-stage feedback)
  function automatic logic [3:0] ref_step(logic [3:0] s, logic [3:0] t);
    logic f;
    f = (^(s & t)) ^ (s == 4'b0000);
    return {f, s[3:1]};
  endfunction

  // Driver: applies one cycle of inputs and queues the expected state
  task automatic drive(bit r, bit e, bit l, logic [3:0] s, logic [3:0] exp, string tag);
    exp_t it;
    @(negedge clk);
    rst = r; en = e; load = l; seed = s;
    @(posedge clk);
    #1;
    it.st = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t it;
      it = sbq.pop_front();
      check(st_a == it.st && ser_a == it.st[0], it.tag, {11'd0, ser_a, st_a}, {11'd0, it.st[0], it.st});
    end
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] model;
    int per_a, per_b, per_c, per_g, per_w;
    logic [15:0] seen;
    bit hit_zero;
    logic [63:0] ybits;
    bit rec_ok;

    // R1: reset
    drive(1, 0, 0, 4'h0, 4'b0001, "R1 reset");
    drive(1, 0, 0, 4'h0, 4'b0001, "R1 reset hold");
    model = 4'b0001;
    // R4: stepping
    for (int k = 0; k < 5; k++) begin
      model = ref_step(model, 4'b0011);
      drive(0, 1, 0, 4'h0, model, "R4 step");
    end
    // R3: hold
    drive(0, 0, 0, 4'hF, model, "R3 hold");
    drive(0, 0, 0, 4'h5, model, "R3 hold");
    // R2: load wins over enable
    drive(0, 1, 1, 4'b1010, 4'b1010, "R2 load with en");
    model = 4'b1010;
    for (int k = 0; k < 3; k++) begin
      model = ref_step(model, 4'b0011);
      drive(0, 1, 0, 4'h0, model, "R4 step after load");
    end
    // R2 + R5: load zero, then escape
    drive(0, 1, 1, 4'b0000, 4'b0000, "R2 load zero");
    drive(0, 1, 0, 4'h0, 4'b1000, "R5 zero escape");
    drive(0, 1, 0, 4'h0, 4'b0100, "R5 after escape");
    drive(0, 0, 1, 4'b0110, 4'b0110, "R2 load without en");
    drive(0, 0, 0, 4'h0, 4'b0110, "R3 hold after load");
    // R1: reset beats load and enable
    drive(1, 1, 1, 4'b1111, 4'b0001, "R1 reset priority");
    @(negedge clk);
    @(negedge clk);

    // Period measurement on all instances
    rst = 0; en = 1; load = 1; seed = 4'b1000; seed3 = 3'b001;
    @(negedge clk);
    load = 0;
    per_a = 0; per_b = 0; per_c = 0; per_g = 0; per_w = 0;
    seen = '0; hit_zero = 0; ybits = '0;
    seen[st_a] = 1'b1;
    ybits[0] = ser_g;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      seen[st_a] = 1'b1;
      ybits[k] = ser_g;
      if (st_a == 0 || st_b == 0 || st_g == 0 || st_w == 0) hit_zero = 1;
      if (per_a == 0 && st_a == 4'b1000) per_a = k;
      if (per_b == 0 && st_b == 4'b1000) per_b = k;
      if (per_c == 0 && st_c == 4'b1000) per_c = k;
      if (per_g == 0 && st_g == 4'b1000) per_g = k;
      if (per_w == 0 && st_w == 3'b001) per_w = k;
    end
    en = 0;
    check(per_a == 15, "R6 period x^4+x+1", per_a[15:0], 16'd15);
    check(seen == 16'hFFFE, "R6 all nonzero states", seen, 16'hFFFE);
    check(per_w == 7, "R7 period x^3+x+1", per_w[15:0], 16'd7);
    check(per_c == 6, "R8 period x^4+x^2+1", per_c[15:0], 16'd6);
    check(per_b == 15, "R10 period x^4+x^3+1", per_b[15:0], 16'd15);
    check(per_g == 15, "R9 internal-xor period", per_g[15:0], 16'd15);
    check(!hit_zero, "R11 never zero", {15'd0, hit_zero}, 16'd0);
    rec_ok = 1;
    for (int t = 0; t + 4 <= 40; t++)
      if (ybits[t+4] != (ybits[t+1] ^ ybits[t])) rec_ok = 0;
    check(rec_ok, "R9 recurrence", {15'd0, rec_ok}, 16'd1);

    // Zero escape on internal-xor and 3-stage builds
    @(negedge clk);
    load = 1; seed = 4'b0000; seed3 = 3'b000;
    @(negedge clk);
    load = 0; en = 1;
    @(negedge clk);
    en = 0;
    check(st_g == 4'b1100, "R9 internal-xor escape", {12'd0, st_g}, 16'h000C);
    check(st_w == 3'b100, "R5 3-stage escape", {13'd0, st_w}, 16'h0004);
    check(st_a == 4'b1000, "R5 escape again", {12'd0, st_a}, 16'h0008);
    @(negedge clk);
    check(st_g == 4'b1100, "R3 internal-xor hold", {12'd0, st_g}, 16'h000C);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule